// File: doc/BRIEF.md
# Serial Flash Status Register and Write-Protection Gate

This block is the status and protection section of a serial-flash slave model. It watches an SPI link (mode 0: chip select active low, data captured on the rising clock edge, driven on the falling edge). It decodes the four status-related opcodes: status read, write-enable set, write-enable clear and status write. It holds the write-enable flag, a busy countdown, two region-guard bits and a status-lock bit. The SPI lines are sampled by the block's own system clock, so the SPI clock must be several times slower than that clock.

A separate command decoder presents program and erase requests on a simple one-cycle request port. The block answers each request one cycle later with an accept or reject pulse. When it accepts a request, it starts a busy interval whose length depends on the kind of request. The decoder tells the block whether the target address lies in the guarded region. The mapping from guard bits to address range is computed outside this block. The status lock together with the active-low protect pin can freeze the lock and guard bits against status writes.

Top module: `flash_status_ctrl`

## Requirements
- R1: The status byte is {lock, 0, 0, 0, guard1, guard0, wen, busy}, most significant bit first. Bits 6 to 4 always read 0. After reset the byte reads 8'h00 and busy_timer is 0.
- R2: Opcode 8'h05 followed by further clock cycles with cs_n low returns the status byte repeatedly. The value is reloaded live at the start of each byte, and this also works while busy. MISO is 0 while cs_n is high.
- R3: Opcode 8'h06 sets wen and opcode 8'h04 clears it. Either takes effect only when cs_n rises after exactly 8 bits.
- R4: Opcode 8'h01 plus one data byte, with cs_n rising after exactly 16 bits, writes lock from data bit 7 and guard1/guard0 from data bits 3/2. All other data bits are ignored. An accepted write holds busy for WR_CYC cycles, then clears busy and wen.
- R5: When lock is 1 and wp_n is 0, a status write is refused. Lock, guard and wen keep their values and busy stays 0.
- R6: When wen is 0, a status write is ignored and every program or erase request is rejected.
- R7: A bulk erase (req_kind 2'b10) is accepted only when both guard bits are 0.
- R8: A page program (req_kind 2'b00) or a sector erase (2'b01) is rejected when a guard bit is 1 and req_in_region is 1. Otherwise it passes this test.
- R9: The block answers each req_valid in the following cycle with exactly one of req_accept or req_reject. Request kind 2'b11 is always rejected. On accept, busy_timer loads PP_CYC, SE_CYC or BE_CYC according to the kind, counts down by one per cycle, and wen clears when it reaches 0. A rejected request leaves busy at 0 and wen unchanged.
- R10: While busy, requests are rejected and opcodes 8'h06, 8'h04 and 8'h01 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | SPI data into the block |
| wp_n | input | 1 | Active-low write-protect pin |
| req_valid | input | 1 | One-cycle program/erase request strobe |
| req_kind | input | 2 | 00 page program, 01 sector erase, 10 bulk erase, 11 invalid |
| req_in_region | input | 1 | Request address lies in the guarded region |
| miso | output | 1 | SPI data out of the block |
| req_accept | output | 1 | Request accepted (one cycle) |
| req_reject | output | 1 | Request rejected (one cycle) |
| busy_timer | output | TW | Remaining busy cycles, 0 when idle |

## Verification
The hardest situation to reach is a continuous status read whose earlier bytes show busy and whose later bytes show the cycle finished. To get there, the bench issues a status write and then holds cs_n low through several status bytes spanning more than WR_CYC cycles. It then checks that the first and last bytes differ in busy and wen. A second hard case is traffic arriving during a busy interval. The bench accepts a sector erase and, within its interval, sends a status write, a write-enable clear, a status read and another request. It then confirms after the interval that none of them changed the state.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_WEN_SET = 8'h06;
    localparam logic [7:0] OP_WEN_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_WR = 8'h01;

    typedef enum logic [1:0] {
        REQ_PAGE   = 2'b00,
        REQ_SECTOR = 2'b01,
        REQ_BULK   = 2'b10,
        REQ_NONE   = 2'b11
    } req_kind_e;

    localparam int SB_LOCK   = 7;
    localparam int SB_GUARD1 = 3;
    localparam int SB_GUARD0 = 2;

endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import flash_stat_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          mosi,
    input  logic [7:0]    stat_byte,
    output logic          frame_end,
    output logic [CW-1:0] frame_bits,
    output logic [7:0]    frame_op,
    output logic [7:0]    frame_data,
    output logic          miso
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        logic          sck;
        logic          cs;
        logic [7:0]    sh;
        logic [7:0]    op;
        logic [CW-1:0] cnt;
        logic          rd;
        logic [6:0]    osh;
        logic [2:0]    ocnt;
        logic          miso;
    } rx_t;

    rx_t q, d;
    logic rise, fall;
    logic [7:0] sh_next;

    always_comb begin
        d       = q;
        d.sck   = sck;
        d.cs    = cs_n;
        rise    = !cs_n && sck && !q.sck;
        fall    = !cs_n && !sck && q.sck;
        sh_next = {q.sh[6:0], mosi};
        if (cs_n) begin
            d.cnt  = '0;
            d.rd   = 1'b0;
            d.ocnt = '0;
            d.miso = 1'b0;
        end else begin
            if (rise) begin
                d.sh = sh_next;
                if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(7)) begin
                    d.op = sh_next;
                    d.rd = (sh_next == OP_STAT_RD);
                end
            end
            if (fall && q.rd) begin
                if (q.ocnt == 3'd0) begin
                    d.miso = stat_byte[7];
                    d.osh  = stat_byte[6:0];
                    d.ocnt = 3'd7;
                end else begin
                    d.miso = q.osh[6];
                    d.osh  = {q.osh[5:0], 1'b0};
                    d.ocnt = q.ocnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.cs  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign frame_end  = cs_n && !q.cs;
    assign frame_bits = q.cnt;
    assign frame_op   = q.op;
    assign frame_data = q.sh;
    assign miso       = q.miso;

    // R2: output is quiet once select has been high for a cycle
    a_r2_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && q.cs) |-> !q.miso);

    // R3: bit counter restarts for every new frame
    a_r3_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (q.cnt == '0));

endmodule

// File: rtl/flash_stat_core.sv
module flash_stat_core
    import flash_stat_pkg::*;
#(
    parameter int CW     = 5,
    parameter int TW     = 8,
    parameter int WR_CYC = 100,
    parameter int PP_CYC = 120,
    parameter int SE_CYC = 160,
    parameter int BE_CYC = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wp_n,
    input  logic          frame_end,
    input  logic [CW-1:0] frame_bits,
    input  logic [7:0]    frame_op,
    input  logic [7:0]    frame_data,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_in_region,
    output logic [7:0]    stat_byte,
    output logic          req_accept,
    output logic          req_reject,
    output logic [TW-1:0] busy_timer
);

    typedef struct packed {
        logic          lock;
        logic [1:0]    guard;
        logic          wen;
        logic [TW-1:0] timer;
        logic          acc;
        logic          rej;
    } st_t;

    st_t q, d;
    logic busy, hw_lock, any_guard, wr_go, is8, is16, kind_ok;
    logic [TW-1:0] kind_cyc;
    logic unused_data;

    assign unused_data = ^{frame_data[6:4], frame_data[1:0]};

    always_comb begin
        busy      = (q.timer != '0);
        hw_lock   = q.lock && !wp_n;
        any_guard = |q.guard;
        is8       = (frame_bits == CW'(8));
        is16      = (frame_bits == CW'(16));
        wr_go     = frame_end && is16 && (frame_op == OP_STAT_WR)
                    && !busy && q.wen && !hw_lock;

        d     = q;
        d.acc = 1'b0;
        d.rej = 1'b0;

        if (busy) d.timer = q.timer - 1'b1;
        if (q.timer == TW'(1)) d.wen = 1'b0;

        if (frame_end && is8 && !busy) begin
            if (frame_op == OP_WEN_SET) d.wen = 1'b1;
            if (frame_op == OP_WEN_CLR) d.wen = 1'b0;
        end

        if (wr_go) begin
            d.lock  = frame_data[SB_LOCK];
            d.guard = {frame_data[SB_GUARD1], frame_data[SB_GUARD0]};
            d.timer = TW'(WR_CYC);
        end

        kind_ok  = 1'b0;
        kind_cyc = '0;
        case (req_kind_e'(req_kind))
            REQ_PAGE: begin
                kind_ok  = !(any_guard && req_in_region);
                kind_cyc = TW'(PP_CYC);
            end
            REQ_SECTOR: begin
                kind_ok  = !(any_guard && req_in_region);
                kind_cyc = TW'(SE_CYC);
            end
            REQ_BULK: begin
                kind_ok  = !any_guard;
                kind_cyc = TW'(BE_CYC);
            end
            default: begin
                kind_ok  = 1'b0;
                kind_cyc = '0;
            end
        endcase

        if (req_valid) begin
            if (kind_ok && q.wen && !busy && !wr_go) begin
                d.timer = kind_cyc;
                d.acc   = 1'b1;
            end else begin
                d.rej   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stat_byte  = {q.lock, 3'b000, q.guard, q.wen, busy};
    assign req_accept = q.acc;
    assign req_reject = q.rej;
    assign busy_timer = q.timer;

    // R9: never both strobes at once
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.acc && q.rej));

    // R9: busy interval counts down one step per cycle
    a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (q.timer == $past(q.timer) - 1'b1));

    // R9: write enable is gone once the interval ends
    a_r9_wen_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (q.timer == TW'(1)) |=> !q.wen);

    // R10: requests during busy are refused
    a_r10_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> q.rej);

    // R6: requests without write enable are refused
    a_r6_wen_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !q.wen) |=> q.rej);

    // R7: bulk erase refused with any guard bit set
    a_r7_bulk_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == REQ_BULK && any_guard) |=> q.rej);

    // R5: hardware lock freezes lock and guard bits
    a_r5_hw_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && hw_lock) |=> $stable({q.lock, q.guard}));

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl #(
    parameter int WR_CYC = 100,
    parameter int PP_CYC = 120,
    parameter int SE_CYC = 160,
    parameter int BE_CYC = 200,
    parameter int CW     = 5,
    localparam int MAX_A = (WR_CYC > PP_CYC) ? WR_CYC : PP_CYC,
    localparam int MAX_B = (SE_CYC > BE_CYC) ? SE_CYC : BE_CYC,
    localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B,
    localparam int TW    = $clog2(MAXC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          mosi,
    input  logic          wp_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_in_region,
    output logic          miso,
    output logic          req_accept,
    output logic          req_reject,
    output logic [TW-1:0] busy_timer
);

    logic          frame_end;
    logic [CW-1:0] frame_bits;
    logic [7:0]    frame_op;
    logic [7:0]    frame_data;
    logic [7:0]    stat_byte;

    spi_frame_rx #(.CW(CW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck        (sck),
        .mosi       (mosi),
        .stat_byte  (stat_byte),
        .frame_end  (frame_end),
        .frame_bits (frame_bits),
        .frame_op   (frame_op),
        .frame_data (frame_data),
        .miso       (miso)
    );

    flash_stat_core #(
        .CW     (CW),
        .TW     (TW),
        .WR_CYC (WR_CYC),
        .PP_CYC (PP_CYC),
        .SE_CYC (SE_CYC),
        .BE_CYC (BE_CYC)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .wp_n          (wp_n),
        .frame_end     (frame_end),
        .frame_bits    (frame_bits),
        .frame_op      (frame_op),
        .frame_data    (frame_data),
        .req_valid     (req_valid),
        .req_kind      (req_kind),
        .req_in_region (req_in_region),
        .stat_byte     (stat_byte),
        .req_accept    (req_accept),
        .req_reject    (req_reject),
        .busy_timer    (busy_timer)
    );

endmodule

// File: tb/sim_flash_status_ctrl.sv
module sim_flash_status_ctrl;

    localparam int WR = 100, PP = 120, SE = 160, BE = 200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic req_valid = 1'b0, req_in_region = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic miso, req_accept, req_reject;
    logic [7:0] busy_timer;
    int n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    flash_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .wp_n(wp_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_in_region(req_in_region), .miso(miso), .req_accept(req_accept),
        .req_reject(req_reject), .busy_timer(busy_timer)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input int n, input logic [63:0] tx, output logic [63:0] rx);
        rx = '0;
        cs_n = 1'b0;
        repeat (2) tick();
        for (int i = n - 1; i >= 0; i--) begin
            mosi = tx[i];
            sck = 1'b0;
            repeat (2) tick();
            rx[i] = miso;
            sck = 1'b1;
            repeat (2) tick();
        end
        sck = 1'b0;
        repeat (2) tick();
        cs_n = 1'b1;
        repeat (3) tick();
    endtask

    task automatic rd_stat(output logic [7:0] s);
        logic [63:0] rx;
        xfer(16, {48'h0, 8'h05, 8'h00}, rx);
        s = rx[7:0];
    endtask

    task automatic cmd8(input logic [7:0] op);
        logic [63:0] rx;
        xfer(8, {56'h0, op}, rx);
    endtask

    task automatic wr_stat(input logic [7:0] v);
        logic [63:0] rx;
        xfer(16, {48'h0, 8'h01, v}, rx);
    endtask

    task automatic request(input logic [1:0] k, input logic reg_in,
                           output logic a, output logic r, output int t);
        req_kind = k;
        req_in_region = reg_in;
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        a = req_accept;
        r = req_reject;
        t = busy_timer;
    endtask

    task automatic wait_idle();
        while (busy_timer != 0) tick();
        tick();
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1 timer at reset", busy_timer, 0);
        chk("R2 miso idle", miso, 0);
        rd_stat(s);
        chk("R1 status at reset", s, 8'h00);
    endtask

    task automatic t_wen();
        logic [7:0] s;
        logic [63:0] rx;
        cmd8(8'h06);
        rd_stat(s);
        chk("R3 wen set", s, 8'h02);
        cmd8(8'h04);
        rd_stat(s);
        chk("R3 wen clear", s, 8'h00);
        xfer(9, {55'h0, 8'h06, 1'b0}, rx);
        rd_stat(s);
        chk("R3 nine bits ignored", s, 8'h00);
        xfer(7, {57'h0, 7'h03}, rx);
        rd_stat(s);
        chk("R3 seven bits ignored", s, 8'h00);
    endtask

    task automatic t_stat_write();
        logic [7:0] s;
        logic [63:0] rx;
        cmd8(8'h06);
        wr_stat(8'hFC);
        xfer(56, {8'h05, 48'h0}, rx);
        chk("R2 first live byte busy", rx[47:40], 8'h8F);
        chk("R4 after write interval", rx[7:0], 8'h8C);
        cmd8(8'h06);
        xfer(17, {47'h0, 8'h01, 8'h00, 1'b0}, rx);
        rd_stat(s);
        chk("R4 seventeen bits ignored", s, 8'h8E);
    endtask

    task automatic t_hw_lock();
        logic [7:0] s;
        wp_n = 1'b0;
        wr_stat(8'h00);
        rd_stat(s);
        chk("R5 locked write refused", s, 8'h8E);
        chk("R5 no busy", busy_timer, 0);
        wp_n = 1'b1;
        wr_stat(8'h00);
        wait_idle();
        rd_stat(s);
        chk("R4 unlocked write lands", s, 8'h00);
    endtask

    task automatic t_wen_off();
        logic [7:0] s;
        logic a, r;
        int t;
        wr_stat(8'h0C);
        rd_stat(s);
        chk("R6 write without wen", s, 8'h00);
        request(2'b00, 1'b0, a, r, t);
        chk("R6 request without wen", {a, r}, 2'b01);
    endtask

    task automatic t_guard();
        logic [7:0] s;
        logic a, r;
        int t;
        cmd8(8'h06);
        wr_stat(8'h04);
        wait_idle();
        cmd8(8'h06);
        request(2'b10, 1'b0, a, r, t);
        chk("R7 bulk with guard", {a, r}, 2'b01);
        rd_stat(s);
        chk("R9 reject keeps wen", s, 8'h06);
        request(2'b00, 1'b1, a, r, t);
        chk("R8 page in region", {a, r}, 2'b01);
        request(2'b11, 1'b0, a, r, t);
        chk("R9 invalid kind", {a, r}, 2'b01);
        request(2'b00, 1'b0, a, r, t);
        chk("R8 page outside region", {a, r}, 2'b10);
        chk("R9 page load", t, PP);
        repeat (PP - 1) tick();
        chk("R9 timer one left", busy_timer, 1);
        tick();
        chk("R9 timer done", busy_timer, 0);
        rd_stat(s);
        chk("R9 wen cleared", s, 8'h04);
    endtask

    task automatic t_busy();
        logic [7:0] s;
        logic a, r;
        int t;
        cmd8(8'h06);
        wr_stat(8'h00);
        wait_idle();
        cmd8(8'h06);
        request(2'b01, 1'b1, a, r, t);
        chk("R8 sector without guard", {a, r}, 2'b10);
        chk("R9 sector load", t, SE);
        request(2'b00, 1'b0, a, r, t);
        chk("R10 request while busy", {a, r}, 2'b01);
        wr_stat(8'h8C);
        cmd8(8'h04);
        rd_stat(s);
        chk("R10 opcodes ignored while busy", s, 8'h03);
        wait_idle();
        rd_stat(s);
        chk("R10 write during busy dropped", s, 8'h00);
        cmd8(8'h06);
        request(2'b10, 1'b0, a, r, t);
        chk("R7 bulk clear guard", {a, r}, 2'b10);
        chk("R9 bulk load", t, BE);
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_wen();
        t_stat_write();
        t_hw_lock();
        t_wen_off();
        t_guard();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule